// File: doc/BRIEF.md
# Control Endpoint Setup Buffer Guard

This block holds the eight-byte payload of the most recent setup packet that arrives on a control endpoint. Firmware reads that payload one byte at a time, and the block keeps a later setup packet from silently replacing the payload while firmware is still reading it. Firmware picks one of two protection schemes.

In lockout mode, the block ignores every new setup packet from the moment one is stored until firmware acknowledges it. In tripwire mode, which is the reset default, new setup packets are always taken in. Firmware first sets a semaphore bit, then copies the payload, then reads the bit again. The block clears that bit whenever a packet lands, so a cleared bit tells firmware that its copy may be mixed and must be repeated.

A second, independent semaphore protects firmware when it links a new transfer descriptor onto an endpoint that is already primed. Firmware may set or clear this bit. The bit drops whenever the descriptor engine signals, on any of its hazard inputs, that a newly added link might go unseen.

Top module: `ctrl_setup_guard`

## Requirements
- R1: After a synchronous reset, `setup_pending`, `setup_trip`, `add_trip`, `lock_mode` and `rd_data` are all 0, and every buffer byte reads as 0. Tripwire mode is therefore the default.
- R2: An accepted packet stores byte i of the buffer from `pkt_data[8*i+7:8*i]`. Reading the buffer is synchronous: `rd_data` shows the byte at `rd_addr` one cycle after the address is sampled. If a packet is stored on the same edge, the read returns the byte as it was before that packet.
- R3: Every accepted packet sets `setup_pending`. A register write to address 1 with `reg_wdata[0]=1` clears it (write-1-to-clear). A write with bit 0 equal to 0 leaves it as it is. If a packet is accepted on the same edge as a clear, the packet wins.
- R4: Every accepted packet clears `setup_trip`. A register write to address 2 loads `reg_wdata[0]` into `setup_trip`. If a packet is accepted on the same edge as that write, the packet wins and the bit ends at 0.
- R5: A packet is ignored while `lock_mode` is 1 and `setup_pending` is 1. In that case the buffer bytes, `setup_pending` and `setup_trip` keep their values. `lock_mode` is loaded from `reg_wdata[0]` by a write to address 0.
- R6: In lockout mode, clearing `setup_pending` releases the lock, so the next packet after the clear is accepted.
- R7: In tripwire mode, every packet is accepted, whether or not `setup_pending` is set.
- R8: A register write to address 3 loads `reg_wdata[0]` into `add_trip`.
- R9: If any bit of `hazard` is 1 on an edge, `add_trip` is 0 after that edge, even if a write on the same edge tries to set it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | A setup packet is offered this cycle |
| pkt_data | input | 64 | Setup payload, byte i in bits 8i+7..8i |
| rd_addr | input | 3 | Buffer byte index for the firmware read port |
| rd_data | output | 8 | Registered byte read from the buffer |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 mode, 1 status clear, 2 setup tripwire, 3 add tripwire |
| reg_wdata | input | 32 | Register write data, only bit 0 is used |
| hazard | input | 2 | Hazard-window indications from the descriptor engine |
| setup_pending | output | 1 | A stored setup packet awaits acknowledgement |
| setup_trip | output | 1 | Setup read semaphore |
| add_trip | output | 1 | Add-descriptor semaphore |
| lock_mode | output | 1 | 1 selects lockout mode, 0 selects tripwire mode |

## Verification
The embedded properties check on every cycle the rules each state bit must follow from one edge to the next. An accepted packet must set pending and clear the setup semaphore. The setup semaphore may rise only after a firmware write. The semaphore must hold while a lockout is engaged. A hazard must leave the add semaphore low. Only the bench scenarios can show that the buffer bytes themselves survive an ignored packet. The same goes for the lock releasing after a clear and for the reads in a firmware copy loop returning the right bytes. These are checked against a cycle model running under directed sequences and random stimulus.

// File: rtl/setup_guard_pkg.sv
package setup_guard_pkg;
  typedef enum logic [1:0] {
    REG_MODE  = 2'd0,
    REG_ACK   = 2'd1,
    REG_STRIP = 2'd2,
    REG_ATRIP = 2'd3
  } guard_reg_e;
endpackage

// File: rtl/setup_buffer.sv
module setup_buffer #(
  parameter int BYTES = 8,
  localparam int AW = $clog2(BYTES),
  localparam int PW = BYTES * 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [PW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [BYTES];

  // one write lane per byte of the payload
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)     mem[g] <= '0;
      else if (we) mem[g] <= wdata[8*g +: 8];
    end
  end

  // read-before-write registered port
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end

  // R2: a stored byte appears on the read port one cycle after it is addressed
  assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (rdata == $past(mem[raddr])));
endmodule

// File: rtl/setup_semaphore.sv
module setup_semaphore (
  input  logic clk,
  input  logic rst,
  input  logic pkt_valid,
  input  logic mode_wr,
  input  logic mode_val,
  input  logic ack_w1c,
  input  logic trip_wr,
  input  logic trip_val,
  output logic accept,
  output logic pending_q,
  output logic trip_q,
  output logic lock_q
);
  logic engaged;

  assign engaged = lock_q && pending_q;
  assign accept  = pkt_valid && !engaged;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      trip_q    <= 1'b0;
      lock_q    <= 1'b0;
    end else begin
      if (mode_wr) lock_q <= mode_val;
      if (accept)       pending_q <= 1'b1;
      else if (ack_w1c) pending_q <= 1'b0;
      if (accept)       trip_q <= 1'b0;
      else if (trip_wr) trip_q <= trip_val;
    end
  end

  assert_accept_sets_pending_R3: assert property (@(posedge clk) disable iff (rst)
    accept |=> pending_q);
  assert_accept_clears_trip_R4: assert property (@(posedge clk) disable iff (rst)
    accept |=> !trip_q);
  assert_trip_rise_by_write_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(trip_q) |-> $past(trip_wr && trip_val));
endmodule

// File: rtl/add_tripwire.sv
module add_tripwire #(
  parameter int HAZARDS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HAZARDS-1:0] hazard,
  input  logic               wr,
  input  logic               val,
  output logic               trip_q
);
  always_ff @(posedge clk) begin
    if (rst)         trip_q <= 1'b0;
    else if (|hazard) trip_q <= 1'b0;
    else if (wr)      trip_q <= val;
  end

  assert_hazard_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (|hazard) |=> !trip_q);
  assert_add_trip_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(trip_q) |-> $past(wr && val));
endmodule

// File: rtl/ctrl_setup_guard.sv
module ctrl_setup_guard
  import setup_guard_pkg::*;
#(
  parameter int BYTES   = 8,
  parameter int HAZARDS = 2,
  parameter int REG_W   = 32,
  localparam int AW = $clog2(BYTES),
  localparam int PW = BYTES * 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pkt_valid,
  input  logic [PW-1:0]      pkt_data,
  input  logic [AW-1:0]      rd_addr,
  output logic [7:0]         rd_data,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  input  logic [HAZARDS-1:0] hazard,
  output logic               setup_pending,
  output logic               setup_trip,
  output logic               add_trip,
  output logic               lock_mode
);
  logic       accept;
  guard_reg_e sel;
  logic       mode_wr, ack_w1c, strip_wr, atrip_wr;

  assign sel      = guard_reg_e'(reg_addr);
  assign mode_wr  = reg_wr && (sel == REG_MODE);
  assign ack_w1c  = reg_wr && (sel == REG_ACK) && reg_wdata[0];
  assign strip_wr = reg_wr && (sel == REG_STRIP);
  assign atrip_wr = reg_wr && (sel == REG_ATRIP);

  setup_semaphore u_sem (
    .clk       (clk),
    .rst       (rst),
    .pkt_valid (pkt_valid),
    .mode_wr   (mode_wr),
    .mode_val  (reg_wdata[0]),
    .ack_w1c   (ack_w1c),
    .trip_wr   (strip_wr),
    .trip_val  (reg_wdata[0]),
    .accept    (accept),
    .pending_q (setup_pending),
    .trip_q    (setup_trip),
    .lock_q    (lock_mode)
  );

  setup_buffer #(.BYTES(BYTES)) u_buf (
    .clk   (clk),
    .rst   (rst),
    .we    (accept),
    .wdata (pkt_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  add_tripwire #(.HAZARDS(HAZARDS)) u_atw (
    .clk    (clk),
    .rst    (rst),
    .hazard (hazard),
    .wr     (atrip_wr),
    .val    (reg_wdata[0]),
    .trip_q (add_trip)
  );

  assert_locked_keeps_trip_R5: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && lock_mode && setup_pending && !strip_wr) |=> $stable(setup_trip));
  assert_locked_keeps_pending_R5: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && lock_mode && setup_pending && !ack_w1c) |=> setup_pending);
  assert_tripmode_accepts_R7: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !lock_mode) |=> (setup_pending && !setup_trip));
endmodule

// File: tb/ctrl_setup_guard_test.sv
module ctrl_setup_guard_test;
  localparam int BYTES = 8;
  localparam int HZ = 2;
  localparam int AW = $clog2(BYTES);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pkt_valid = 1'b0;
  logic [63:0]   pkt_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [HZ-1:0] hazard = '0;
  logic          setup_pending, setup_trip, add_trip, lock_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_mem [BYTES];
  logic [7:0] e_rd;
  logic e_pend, e_strip, e_atrip, e_lock;

  always #4 clk = ~clk;

  ctrl_setup_guard uut (
    .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .hazard(hazard), .setup_pending(setup_pending),
    .setup_trip(setup_trip), .add_trip(add_trip), .lock_mode(lock_mode)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit model_accept(bit pv);
    return pv && !(e_lock && e_pend);
  endfunction

  task automatic cyc(bit pv, logic [63:0] pd, bit rw, logic [1:0] ra, logic [31:0] wd,
                     logic [AW-1:0] raddr, logic [HZ-1:0] hz, string tag);
    bit acc;
    pkt_valid = pv; pkt_data = pd; reg_wr = rw; reg_addr = ra;
    reg_wdata = wd; rd_addr = raddr; hazard = hz;
    acc = model_accept(pv);
    e_rd = m_mem[raddr];
    if (acc) for (int i = 0; i < BYTES; i++) m_mem[i] = pd[8*i +: 8];
    if (acc) e_pend = 1'b1;
    else if (rw && ra == 2'd1 && wd[0]) e_pend = 1'b0;
    if (acc) e_strip = 1'b0;
    else if (rw && ra == 2'd2) e_strip = wd[0];
    if (|hz) e_atrip = 1'b0;
    else if (rw && ra == 2'd3) e_atrip = wd[0];
    if (rw && ra == 2'd0) e_lock = wd[0];
    @(posedge clk);
    @(negedge clk);
    chk(tag, "rd_data", 32'(rd_data), 32'(e_rd));
    chk(tag, "setup_pending", 32'(setup_pending), 32'(e_pend));
    chk(tag, "setup_trip", 32'(setup_trip), 32'(e_strip));
    chk(tag, "add_trip", 32'(add_trip), 32'(e_atrip));
    chk(tag, "lock_mode", 32'(lock_mode), 32'(e_lock));
  endtask

  task automatic idle(logic [AW-1:0] raddr, string tag);
    cyc(1'b0, '0, 1'b0, 2'd0, '0, raddr, '0, tag);
  endtask

  task automatic wreg(logic [1:0] ra, logic [31:0] wd, string tag);
    cyc(1'b0, '0, 1'b1, ra, wd, '0, '0, tag);
  endtask

  task automatic pkt(logic [63:0] pd, string tag);
    cyc(1'b1, pd, 1'b0, 2'd0, '0, '0, '0, tag);
  endtask

  task automatic read_all(string tag);
    for (int i = 0; i < BYTES; i++) idle(AW'(i), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < BYTES; i++) m_mem[i] = '0;
    e_pend = 0; e_strip = 0; e_atrip = 0; e_lock = 0; e_rd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "rd_data", 32'(rd_data), 0);
    chk("R1", "setup_pending", 32'(setup_pending), 0);
    chk("R1", "setup_trip", 32'(setup_trip), 0);
    chk("R1", "add_trip", 32'(add_trip), 0);
    chk("R1", "lock_mode", 32'(lock_mode), 0);
    read_all("R1");

    // R2: store and read back, plus read on the write edge returns old byte
    pkt(64'h8877_6655_4433_2211, "R2");
    read_all("R2");
    cyc(1'b1, 64'h0102_0304_0506_0708, 1'b0, 2'd0, '0, 3'd5, '0, "R2");
    idle(3'd5, "R2");

    // R3: W1C with bit0=0 leaves pending, bit0=1 clears, packet wins
    wreg(2'd1, 32'h0, "R3");
    wreg(2'd1, 32'h1, "R3");
    cyc(1'b1, 64'hAAAA_BBBB_CCCC_DDDD, 1'b1, 2'd1, 32'h1, '0, '0, "R3");

    // R4: firmware copy loop, semaphore knocked down by a packet
    wreg(2'd2, 32'h1, "R4");
    idle(3'd0, "R4");
    pkt(64'h1111_2222_3333_4444, "R4");
    wreg(2'd2, 32'h1, "R4");
    wreg(2'd2, 32'h0, "R4");
    cyc(1'b1, 64'h5555_6666_7777_8888, 1'b1, 2'd2, 32'h1, '0, '0, "R4");

    // R7: tripwire mode accepts with pending set
    wreg(2'd2, 32'h1, "R7");
    pkt(64'hDEAD_BEEF_CAFE_F00D, "R7");
    read_all("R7");

    // R5 and R6: lockout
    wreg(2'd0, 32'h1, "R5");
    wreg(2'd1, 32'h1, "R5");
    pkt(64'h0F0E_0D0C_0B0A_0908, "R5");
    wreg(2'd2, 32'h1, "R5");
    pkt(64'hFFFF_FFFF_FFFF_FFFF, "R5");
    pkt(64'h1234_5678_9ABC_DEF0, "R5");
    read_all("R5");
    wreg(2'd1, 32'h1, "R6");
    pkt(64'h7766_5544_3322_1100, "R6");
    read_all("R6");
    pkt(64'h0, "R6");
    wreg(2'd0, 32'h0, "R7");

    // R8 and R9: add-descriptor semaphore
    wreg(2'd3, 32'h1, "R8");
    wreg(2'd3, 32'h0, "R8");
    wreg(2'd3, 32'h1, "R8");
    cyc(1'b0, '0, 1'b0, 2'd0, '0, '0, 2'b10, "R9");
    cyc(1'b0, '0, 1'b1, 2'd3, 32'h1, '0, 2'b01, "R9");
    wreg(2'd3, 32'h1, "R9");
    cyc(1'b0, '0, 1'b0, 2'd0, '0, '0, 2'b11, "R9");

    // random mix across both modes
    for (int n = 0; n < 4000; n++) begin
      bit pv, rw;
      logic [1:0] ra;
      pv = ($urandom % 3) == 0;
      rw = ($urandom % 2) == 0;
      ra = 2'($urandom);
      if (ra == 2'd0 && ($urandom % 4) != 0) ra = 2'd2;
      cyc(pv, {$urandom, $urandom}, rw, ra, 32'($urandom % 2),
          AW'($urandom), (($urandom % 6) == 0) ? HZ'($urandom) : '0, "R5_R7_rand");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule